// File: doc/BRIEF.md
# Bus-to-Device Four-Phase Handshake Sequencer

This block is a clocked sequencer that sits between a bus master and a peripheral device with its data transceiver. The master requests a transfer by raising either a read request or a write request. The sequencer then drives a strobe towards the device, waits for the device to acknowledge, and enables the transceiver. It answers the master with a bus acknowledge. Read and write transfers place the transceiver enable differently relative to the two acknowledges. Every signal follows a four-phase protocol: it rises, then returns to zero, before it may rise again.

A single internal phase bit is high from the device acknowledge until the device strobe is withdrawn. It separates the states on the way in from the states on the way out, which would otherwise show the same port values. The phase bit is brought out so that it can be observed. Every output is registered, and at most one of the three handshake outputs changes on any clock.

Protocol faults raise a sticky fault flag: a request while the device acknowledge is still high from the previous transfer, or both requests at once. A slow device raises a sticky timeout flag; its limit in clocks is an input. All inputs are taken to be synchronous to the clock already.

Top module: `hs_bus_dev_seq`

## Requirements
- R1: Read transfer. One clock after a lone read request is sampled in idle with the device acknowledge low, the device strobe rises. One clock after the device acknowledge is sampled high, the transceiver enable rises. On the next clock the bus acknowledge rises.
- R2: Read return. The bus acknowledge, device strobe and transceiver enable hold while the read request stays high. One clock after the read request is sampled low, the transceiver enable falls. On the next clock the device strobe falls. On the clock after that the bus acknowledge falls and the sequencer is idle.
- R3: Write transfer. One clock after a lone write request is sampled in idle with the device acknowledge low, the transceiver enable rises. On the next clock the device strobe rises. One clock after the device acknowledge is sampled high, the transceiver enable falls. On the next clock the bus acknowledge rises.
- R4: Write return. The bus acknowledge and device strobe hold while the write request stays high. One clock after the write request is sampled low, the device strobe falls. On the next clock the bus acknowledge falls and the sequencer is idle.
- R5: The phase output rises on the same clock as the first output change that follows the device acknowledge. It falls together with the device strobe. It is high only while the device strobe is high.
- R6: A read or write request sampled in idle while the device acknowledge is high sets the sticky fault flag and starts nothing. The transfer starts on the first clock that samples the request with the acknowledge low.
- R7: Both requests sampled high together in idle set the sticky fault flag and start neither transfer.
- R8: At most one of bus acknowledge, device strobe and transceiver enable changes per clock. Each of them alternates strictly between rising and falling.
- R9: The sticky timeout flag rises on the clock that samples the device acknowledge low for the L-th time while the strobe waits, where L is the limit input (0 is treated as 1). An acknowledge that arrives earlier leaves the flag low.
- R10: After reset all outputs are low, including the phase bit and both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous release |
| rd_req_i | input | 1 | Read request from the bus master |
| wr_req_i | input | 1 | Write request from the bus master |
| dev_ack_i | input | 1 | Device acknowledge |
| ack_limit_i | input | TMO_W | Clocks to wait for the device acknowledge before timing out |
| bus_ack_o | output | 1 | Acknowledge to the bus master |
| dev_strobe_o | output | 1 | Strobe to the device |
| xcvr_en_o | output | 1 | Transceiver enable |
| phase_o | output | 1 | Internal phase bit: device handshake completed |
| proto_err_o | output | 1 | Sticky protocol fault flag |
| ack_timeout_o | output | 1 | Sticky device timeout flag |

## Verification
Every result is due exactly one clock edge after the input sample that causes it. A multi-step sequence therefore advances one output per edge. The bench changes inputs just after a falling edge and compares the whole output vector at the following falling edge, so each check looks at the state after exactly one rising edge. While the strobe waits, the timeout flag is predicted from the number of low acknowledge samples taken so far against the limit, over a sweep of acknowledge delays on both sides of the limit. Request hold times are swept as well, to show that the outputs stay put until the request falls.

// File: rtl/hs_pkg.sv
package hs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RD_WAIT,
    ST_RD_XON,
    ST_RD_ACK,
    ST_RD_XOFF,
    ST_RD_SOFF,
    ST_WR_XON,
    ST_WR_WAIT,
    ST_WR_XOFF,
    ST_WR_ACK,
    ST_WR_SOFF
  } hs_state_e;

  typedef struct packed {
    logic bus_ack;
    logic dev_stb;
    logic xcvr_en;
    logic phase;
  } hs_out_t;

  // Output pattern held in each state
  function automatic hs_out_t out_of(hs_state_e s);
    hs_out_t o;
    case (s)
      ST_RD_WAIT: o = 4'b0100;
      ST_RD_XON:  o = 4'b0111;
      ST_RD_ACK:  o = 4'b1111;
      ST_RD_XOFF: o = 4'b1101;
      ST_RD_SOFF: o = 4'b1000;
      ST_WR_XON:  o = 4'b0010;
      ST_WR_WAIT: o = 4'b0110;
      ST_WR_XOFF: o = 4'b0101;
      ST_WR_ACK:  o = 4'b1101;
      ST_WR_SOFF: o = 4'b1000;
      default:    o = 4'b0000;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/hs_start_guard.sv
module hs_start_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic idle,
  input  logic rd_req,
  input  logic wr_req,
  input  logic dev_ack,
  output logic go_rd,
  output logic go_wr,
  output logic err_o
);
  logic clash, early, bad;

  assign clash = rd_req & wr_req;
  assign early = (rd_req | wr_req) & dev_ack;
  assign bad   = idle & (clash | early);
  assign go_rd = idle & rd_req & ~wr_req & ~dev_ack;
  assign go_wr = idle & wr_req & ~rd_req & ~dev_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) err_o <= 1'b0;
    else        err_o <= err_o | bad;
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o); // R6

  AST_ERR_ON_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
    idle && rd_req && wr_req |=> err_o); // R7

endmodule

// File: rtl/hs_ack_timer.sv
module hs_ack_timer #(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack_wait,
  input  logic             dev_ack,
  input  logic [TMO_W-1:0] limit,
  output logic             tmo_o
);
  localparam logic [TMO_W-1:0] CNT_MAX = {TMO_W{1'b1}};

  logic [TMO_W-1:0] cnt;
  logic             expire;

  // True when the current low sample is the limit-th one (limit 0 acts as 1)
  function automatic logic due_now(logic [TMO_W-1:0] c, logic [TMO_W-1:0] lim);
    logic [TMO_W:0] next_cnt;
    next_cnt = {1'b0, c} + 1'b1;
    return next_cnt >= {1'b0, lim};
  endfunction

  assign expire = ack_wait & ~dev_ack & due_now(cnt, limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      tmo_o <= 1'b0;
    end else begin
      if (!ack_wait)                      cnt <= '0;
      else if (!dev_ack && cnt != CNT_MAX) cnt <= cnt + 1'b1;
      tmo_o <= tmo_o | expire;
    end
  end

  AST_TMO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_o |=> tmo_o); // R9

  AST_TMO_ONLY_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_o) |-> $past(ack_wait) && !$past(dev_ack)); // R9

endmodule

// File: rtl/hs_step_fsm.sv
module hs_step_fsm
  import hs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    rd_req,
  input  logic    wr_req,
  input  logic    dev_ack,
  input  logic    go_rd,
  input  logic    go_wr,
  output hs_out_t out_q,
  output logic    idle,
  output logic    ack_wait
);
  hs_state_e state, nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE: begin
        if (go_rd)      nxt = ST_RD_WAIT;
        else if (go_wr) nxt = ST_WR_XON;
      end
      ST_RD_WAIT: if (dev_ack) nxt = ST_RD_XON;
      ST_RD_XON:  nxt = ST_RD_ACK;
      ST_RD_ACK:  if (!rd_req) nxt = ST_RD_XOFF;
      ST_RD_XOFF: nxt = ST_RD_SOFF;
      ST_RD_SOFF: nxt = ST_IDLE;
      ST_WR_XON:  nxt = ST_WR_WAIT;
      ST_WR_WAIT: if (dev_ack) nxt = ST_WR_XOFF;
      ST_WR_XOFF: nxt = ST_WR_ACK;
      ST_WR_ACK:  if (!wr_req) nxt = ST_WR_SOFF;
      ST_WR_SOFF: nxt = ST_IDLE;
      default:    nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      out_q <= '0;
    end else begin
      state <= nxt;
      out_q <= out_of(nxt);
    end
  end

  assign idle     = (state == ST_IDLE);
  assign ack_wait = (state == ST_RD_WAIT) || (state == ST_WR_WAIT);

  AST_ONE_OUTPUT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({out_q.bus_ack, out_q.dev_stb, out_q.xcvr_en} ^
               $past({out_q.bus_ack, out_q.dev_stb, out_q.xcvr_en})) <= 1); // R8

  AST_BUS_ACK_AFTER_DEV: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_q.bus_ack) |-> out_q.phase); // R5

  AST_STB_DROP_UNDER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_q.dev_stb) |-> out_q.bus_ack && !out_q.xcvr_en); // R2

  AST_PHASE_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    out_q.phase |-> out_q.dev_stb); // R5

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RD_ACK) && rd_req |=> out_q.bus_ack && out_q.xcvr_en); // R2

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WR_ACK) && wr_req |=> out_q.bus_ack && out_q.dev_stb); // R4

endmodule

// File: rtl/hs_bus_dev_seq.sv
module hs_bus_dev_seq #(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_req_i,
  input  logic             wr_req_i,
  input  logic             dev_ack_i,
  input  logic [TMO_W-1:0] ack_limit_i,
  output logic             bus_ack_o,
  output logic             dev_strobe_o,
  output logic             xcvr_en_o,
  output logic             phase_o,
  output logic             proto_err_o,
  output logic             ack_timeout_o
);
  import hs_pkg::*;

  hs_out_t outs;
  logic    idle, ack_wait, go_rd, go_wr;

  hs_start_guard u_guard (
    .clk     (clk),
    .rst_n   (rst_n),
    .idle    (idle),
    .rd_req  (rd_req_i),
    .wr_req  (wr_req_i),
    .dev_ack (dev_ack_i),
    .go_rd   (go_rd),
    .go_wr   (go_wr),
    .err_o   (proto_err_o)
  );

  hs_step_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_req   (rd_req_i),
    .wr_req   (wr_req_i),
    .dev_ack  (dev_ack_i),
    .go_rd    (go_rd),
    .go_wr    (go_wr),
    .out_q    (outs),
    .idle     (idle),
    .ack_wait (ack_wait)
  );

  hs_ack_timer #(.TMO_W(TMO_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack_wait (ack_wait),
    .dev_ack  (dev_ack_i),
    .limit    (ack_limit_i),
    .tmo_o    (ack_timeout_o)
  );

  assign bus_ack_o    = outs.bus_ack;
  assign dev_strobe_o = outs.dev_stb;
  assign xcvr_en_o    = outs.xcvr_en;
  assign phase_o      = outs.phase;

  AST_CLASH_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    idle && rd_req_i && wr_req_i |=> !dev_strobe_o && !xcvr_en_o); // R7

  AST_EARLY_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    idle && (rd_req_i || wr_req_i) && dev_ack_i |=> !dev_strobe_o && !xcvr_en_o); // R6

endmodule

// File: tb/test_hs_bus_dev_seq.sv
module test_hs_bus_dev_seq;
  localparam int TMO_W = 8;
  localparam int LIM   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd = 1'b0, wr = 1'b0, ack = 1'b0;
  logic [TMO_W-1:0] lim = TMO_W'(LIM);
  logic bus_ack, dev_stb, xcvr, phase, err, tmo;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hs_bus_dev_seq #(.TMO_W(TMO_W)) i_hs_bus_dev_seq (
    .clk(clk), .rst_n(rst_n), .rd_req_i(rd), .wr_req_i(wr), .dev_ack_i(ack),
    .ack_limit_i(lim), .bus_ack_o(bus_ack), .dev_strobe_o(dev_stb),
    .xcvr_en_o(xcvr), .phase_o(phase), .proto_err_o(err), .ack_timeout_o(tmo)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // expected order: {bus_ack, dev_strobe, xcvr_en, phase, proto_err, timeout}
  task automatic chk(input logic [5:0] exp, input string tag);
    logic [5:0] got;
    got = {bus_ack, dev_stb, xcvr, phase, err, tmo};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; rd = 1'b0; wr = 1'b0; ack = 1'b0;
    step(); step();
    rst_n = 1'b1;
    step();
    chk(6'b000000, "R10 reset state");
  endtask

  initial begin
    @(negedge clk);
    // Read sweep over ack delay and request hold
    for (int d = 0; d <= 5; d++) begin
      for (int h = 0; h <= 2; h++) begin
        logic t;
        do_reset();
        t = 1'b0;
        rd = 1'b1; step();
        chk(6'b010000, "R1/R8 device strobe up");
        for (int k = 1; k <= d; k++) begin
          step();
          t = (k >= LIM);
          chk({5'b01000, t}, "R9 read ack wait");
        end
        ack = 1'b1; step();
        chk({5'b01110, t}, "R1/R5 xcvr on, phase up");
        step();
        chk({5'b11110, t}, "R1 bus ack up");
        for (int k = 0; k < h; k++) begin
          step();
          chk({5'b11110, t}, "R2 hold while request high");
        end
        rd = 1'b0; step();
        chk({5'b11010, t}, "R2/R8 xcvr off");
        step();
        chk({5'b10000, t}, "R2/R5 strobe and phase down");
        ack = 1'b0; step();
        chk({5'b00000, t}, "R2 bus ack down, idle");
      end
    end
    // Write sweep
    for (int d = 0; d <= 5; d++) begin
      for (int h = 0; h <= 2; h++) begin
        logic t;
        do_reset();
        t = 1'b0;
        wr = 1'b1; step();
        chk(6'b001000, "R3/R8 xcvr up first");
        step();
        chk(6'b011000, "R3 device strobe up");
        for (int k = 1; k <= d; k++) begin
          step();
          t = (k >= LIM);
          chk({5'b01100, t}, "R9 write ack wait");
        end
        ack = 1'b1; step();
        chk({5'b01010, t}, "R3/R5 xcvr off, phase up");
        step();
        chk({5'b11010, t}, "R3 bus ack up");
        for (int k = 0; k < h; k++) begin
          step();
          chk({5'b11010, t}, "R4 hold while request high");
        end
        wr = 1'b0; step();
        chk({5'b10000, t}, "R4/R5 strobe and phase down");
        ack = 1'b0; step();
        chk({5'b00000, t}, "R4 bus ack down, idle");
      end
    end
    // Early read request with stale device ack
    do_reset();
    ack = 1'b1; rd = 1'b1; step();
    chk(6'b000010, "R6 early read flagged, no start");
    step();
    chk(6'b000010, "R6 still held off");
    ack = 1'b0; step();
    chk(6'b010010, "R6 read starts once ack low");
    // Early write request
    do_reset();
    ack = 1'b1; wr = 1'b1; step();
    chk(6'b000010, "R6 early write flagged, no start");
    // Both requests together
    do_reset();
    rd = 1'b1; wr = 1'b1; step();
    chk(6'b000010, "R7 clash flagged, no start");
    step();
    chk(6'b000010, "R7 clash held, no start");
    rd = 1'b0; step();
    chk(6'b001010, "R7 lone write then starts");
    // Limit of zero acts as one
    do_reset();
    lim = '0;
    rd = 1'b1; step();
    chk(6'b010000, "R9 limit zero strobe");
    step();
    chk(6'b010001, "R9 limit zero first low sample");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule